// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation buffer that maps virtual page numbers to physical frame numbers. Each slot holds a page number, a per-slot ignore mask for page-number bits, an address-space tag, a shared-page bit, an even-page and an odd-page valid bit, and a frame number. The lookup port takes a full virtual address, the current address-space tag and an instruction-fetch flag. One cycle later it returns hit, frame, an uncacheable flag and an alignment fault. A probe port returns the index of the matching slot instead of its frame.

Slots are filled by an indexed write port and emptied all at once by a flush. A replacement pointer walks the slots in order, and the slot it points at can be read at the block's outputs. Filling the buffer, choosing what to write and reacting to misses or faults belong to the surrounding logic.

Top module: `asid_tlb`

## Requirements
- R1: A slot matches only when the request page number (virtual address bits above the 12-bit page offset) equals the stored page number on every bit where the slot's mask bit is 0. Bits where the mask is 1 are ignored.
- R2: Besides the page number, a slot matches only when its shared bit is 1 or its stored tag equals the request tag.
- R3: Lookup results appear one cycle after `lk_valid`. When several slots match, the lowest-numbered one supplies `rsp_pfn`. On a miss or a fault `rsp_pfn` is 0.
- R4: A probe returns the matching slot index on `pr_index` one cycle after `pr_valid`. When no slot matches, it returns all ones (15 for a 4-bit index).
- R5: A slot takes part in matching only when its even or odd valid bit is set. `vic_occ` shows the OR of the two valid bits for the slot under the replacement pointer.
- R6: A write with `wr_idx` below ENTRIES replaces that slot. A write with `wr_idx` of ENTRIES or more changes no slot and sets `wr_err` in the following cycle. `wr_err` is 0 after any accepted write.
- R7: A flush empties every slot and returns the replacement pointer to 0. A write in the same cycle as a flush is discarded.
- R8: The replacement pointer steps by one per cycle with `vic_adv` high and wraps from ENTRIES-1 to 0. `vic_vpn`, `vic_pfn` and `vic_occ` show the slot it currently points at.
- R9: `rsp_uncached` is 1 exactly when the virtual address ANDed with 0xA0000000 equals 0xA0000000. This holds even on a fault.
- R10: An instruction-fetch lookup whose address bits [1:0] are not 00 sets `rsp_fault` and reports no hit. A data lookup never faults.
- R11: A lookup in the same cycle as a write sees the old slot contents. The new contents are visible from the next cycle.
- R12: After reset every slot is empty, the pointer is 0, `rsp_*` and `wr_err` are 0, and `pr_index` is all ones.

Write ports carry the fields of the slot to be replaced: `wr_idx`, `wr_vpn`, `wr_mask`, `wr_asid`, `wr_global`, `wr_v0`, `wr_v1` and `wr_pfn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Lookup address-space tag |
| lk_ifetch | input | 1 | Lookup is an instruction fetch |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | PFN_W | Frame number of the hit slot |
| rsp_uncached | output | 1 | Address lies in the uncacheable window |
| rsp_fault | output | 1 | Misaligned instruction fetch |
| pr_valid | input | 1 | Probe request |
| pr_vpn | input | VPN_W | Probe page number |
| pr_asid | input | ASID_W | Probe address-space tag |
| pr_done | output | 1 | Probe result valid |
| pr_index | output | IDX_W | Matching slot index, all ones when none |
| wr_en | input | 1 | Indexed write |
| wr_idx | input | IDX_W | Slot to replace |
| wr_vpn | input | VPN_W | New page number |
| wr_mask | input | VPN_W | New ignore mask |
| wr_asid | input | ASID_W | New address-space tag |
| wr_global | input | 1 | New shared bit |
| wr_v0 | input | 1 | New even-page valid |
| wr_v1 | input | 1 | New odd-page valid |
| wr_pfn | input | PFN_W | New frame number |
| wr_err | output | 1 | Previous write was out of range |
| flush | input | 1 | Empty all slots |
| vic_adv | input | 1 | Advance replacement pointer |
| vic_ptr | output | PTR_W | Replacement pointer |
| vic_vpn | output | VPN_W | Page number of the slot under the pointer |
| vic_pfn | output | PFN_W | Frame number of the slot under the pointer |
| vic_occ | output | 1 | Slot under the pointer is occupied |

## Verification
The bench builds the block with ENTRIES = 6, which is not a power of two. The wrap check therefore goes from 5 to 0 rather than on a natural counter overflow. With a 4-bit index, indices 6, 7 and 15 can be driven on the write port as out-of-range values, and the all-ones not-found code 15 stays distinct from every real slot. The six slots cover these cases together: duplicate matches, a masked slot, a shared slot, a slot with both valid bits clear, and two slots with the same page number under different tags.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Page offset width: the page number starts above this bit.
  localparam int unsigned TLB_PG_SHIFT = 12;

  // Instruction fetch must be word aligned.
  function automatic logic tlb_misaligned(input logic [1:0] lo);
    return lo != 2'b00;
  endfunction

  // Address falls in the uncacheable window when every window bit is set.
  function automatic logic tlb_uncached(input logic [63:0] va, input logic [63:0] win);
    return (va & win) == win;
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic [PFN_W-1:0]  wr_pfn,
  output logic [VPN_W-1:0]  e_vpn  [ENTRIES],
  output logic [VPN_W-1:0]  e_mask [ENTRIES],
  output logic [ASID_W-1:0] e_asid [ENTRIES],
  output logic              e_glob [ENTRIES],
  output logic              e_occ  [ENTRIES],
  output logic [PFN_W-1:0]  e_pfn  [ENTRIES],
  output logic              wr_reject,
  output logic              wr_err
);

  logic in_range;
  logic wr_take;
  logic e_v0 [ENTRIES];
  logic e_v1 [ENTRIES];

  assign in_range  = wr_idx < IDX_W'(ENTRIES);
  assign wr_take   = wr_en && in_range && !flush;
  assign wr_reject = wr_en && !in_range;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        e_vpn[g]  <= '0;
        e_mask[g] <= '0;
        e_asid[g] <= '0;
        e_glob[g] <= 1'b0;
        e_v0[g]   <= 1'b0;
        e_v1[g]   <= 1'b0;
        e_pfn[g]  <= '0;
      end else if (flush) begin
        e_vpn[g]  <= '0;
        e_mask[g] <= '0;
        e_asid[g] <= '0;
        e_glob[g] <= 1'b0;
        e_v0[g]   <= 1'b0;
        e_v1[g]   <= 1'b0;
        e_pfn[g]  <= '0;
      end else if (wr_take && wr_idx == IDX_W'(g)) begin
        e_vpn[g]  <= wr_vpn;
        e_mask[g] <= wr_mask;
        e_asid[g] <= wr_asid;
        e_glob[g] <= wr_global;
        e_v0[g]   <= wr_v0;
        e_v1[g]   <= wr_v1;
        e_pfn[g]  <= wr_pfn;
      end
    end
    assign e_occ[g] = e_v0[g] | e_v1[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= wr_reject;
  end

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned PTR_W   = 3
) (
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  input  logic [VPN_W-1:0]  e_vpn  [ENTRIES],
  input  logic [VPN_W-1:0]  e_mask [ENTRIES],
  input  logic [ASID_W-1:0] e_asid [ENTRIES],
  input  logic              e_glob [ENTRIES],
  input  logic              e_occ  [ENTRIES],
  input  logic [PFN_W-1:0]  e_pfn  [ENTRIES],
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [PFN_W-1:0]  pfn
);

  // Page numbers agree wherever the slot does not ignore the bit.
  function automatic logic vpn_agree(input logic [VPN_W-1:0] a,
                                     input logic [VPN_W-1:0] b,
                                     input logic [VPN_W-1:0] ign);
    return ((a ^ b) & ~ign) == '0;
  endfunction

  logic [ENTRIES-1:0] hv;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hv[g] = e_occ[g]
                && vpn_agree(key_vpn, e_vpn[g], e_mask[g])
                && (e_glob[g] || e_asid[g] == key_asid);
  end

  // Lowest matching index wins; all ones when nothing matches.
  always_comb begin
    idx = '1;
    hit = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hv[i]) begin
        idx = IDX_W'(i);
        hit = 1'b1;
      end
    end
  end

  assign pfn = hit ? e_pfn[idx[PTR_W-1:0]] : '0;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PTR_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (flush) ptr <= '0;
    else if (adv)   ptr <= step(ptr);
  end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ASID_W  = 8,
  parameter logic [VA_W-1:0] UC_WIN = VA_W'(32'hA000_0000),
  localparam int unsigned VPN_W  = VA_W - TLB_PG_SHIFT,
  localparam int unsigned PTR_W  = $clog2(ENTRIES),
  localparam int unsigned IDX_W  = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_ifetch,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic              rsp_uncached,
  output logic              rsp_fault,
  input  logic              pr_valid,
  input  logic [VPN_W-1:0]  pr_vpn,
  input  logic [ASID_W-1:0] pr_asid,
  output logic              pr_done,
  output logic [IDX_W-1:0]  pr_index,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic [PFN_W-1:0]  wr_pfn,
  output logic              wr_err,
  input  logic              flush,
  input  logic              vic_adv,
  output logic [PTR_W-1:0]  vic_ptr,
  output logic [VPN_W-1:0]  vic_vpn,
  output logic [PFN_W-1:0]  vic_pfn,
  output logic              vic_occ
);

  logic [VPN_W-1:0]  e_vpn  [ENTRIES];
  logic [VPN_W-1:0]  e_mask [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic              e_glob [ENTRIES];
  logic              e_occ  [ENTRIES];
  logic [PFN_W-1:0]  e_pfn  [ENTRIES];

  // Named internal events, observed by the checker.
  logic evt_wr_reject;
  logic evt_lk_fault;
  logic evt_lk_uc;

  logic             l_hit, p_hit;
  logic [IDX_W-1:0] l_idx, p_idx;
  logic [PFN_W-1:0] l_pfn, p_pfn;

  assign evt_lk_fault = lk_valid && lk_ifetch && tlb_misaligned(lk_va[1:0]);
  assign evt_lk_uc    = tlb_uncached(64'(lk_va), 64'(UC_WIN));

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
              .ASID_W(ASID_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_v0(wr_v0), .wr_v1(wr_v1),
    .wr_pfn(wr_pfn),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_occ(e_occ), .e_pfn(e_pfn),
    .wr_reject(evt_wr_reject), .wr_err(wr_err)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
              .ASID_W(ASID_W), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_lk_match (
    .key_vpn(lk_va[VA_W-1:TLB_PG_SHIFT]), .key_asid(lk_asid),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_occ(e_occ), .e_pfn(e_pfn),
    .hit(l_hit), .idx(l_idx), .pfn(l_pfn)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
              .ASID_W(ASID_W), .IDX_W(IDX_W), .PTR_W(PTR_W)) u_pr_match (
    .key_vpn(pr_vpn), .key_asid(pr_asid),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .e_occ(e_occ), .e_pfn(e_pfn),
    .hit(p_hit), .idx(p_idx), .pfn(p_pfn)
  );

  tlb_victim #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush(flush), .adv(vic_adv), .ptr(vic_ptr)
  );

  assign vic_vpn = e_vpn[vic_ptr];
  assign vic_pfn = e_pfn[vic_ptr];
  assign vic_occ = e_occ[vic_ptr];

  logic lk_go;
  assign lk_go = lk_valid && !evt_lk_fault && l_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_pfn      <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= 1'b0;
      pr_done      <= 1'b0;
      pr_index     <= '1;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= lk_go;
      rsp_pfn      <= lk_go ? l_pfn : '0;
      rsp_uncached <= lk_valid && evt_lk_uc;
      rsp_fault    <= evt_lk_fault;
      pr_done      <= pr_valid;
      pr_index     <= pr_valid ? p_idx : '1;
    end
  end

  // The probe reports the index only; its frame is not needed.
  logic unused_probe;
  assign unused_probe = p_hit ^ (^p_pfn) ^ (^l_idx);

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned PTR_W   = 3,
  parameter int unsigned IDX_W   = 4,
  parameter logic [VA_W-1:0] UC_WIN = VA_W'(32'hA000_0000)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VA_W-1:0]  lk_va,
  input logic             lk_ifetch,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PFN_W-1:0] rsp_pfn,
  input logic             rsp_uncached,
  input logic             rsp_fault,
  input logic             pr_done,
  input logic [IDX_W-1:0] pr_index,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_err,
  input logic             flush,
  input logic             vic_adv,
  input logic [PTR_W-1:0] vic_ptr,
  input logic             evt_lk_fault
);

  assert_flush_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> vic_ptr == '0);

  assert_wr_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx >= IDX_W'(ENTRIES) |=> wr_err);

  assert_wr_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx < IDX_W'(ENTRIES) |=> !wr_err);

  assert_fault_nohit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ifetch && lk_va[1:0] != 2'b00 |=> rsp_fault && !rsp_hit && rsp_pfn == '0);

  assert_data_nofault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_lk_fault |=> !rsp_fault);

  assert_probe_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pr_done |-> (pr_index == '1 || pr_index < IDX_W'(ENTRIES)));

  assert_vic_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vic_adv && !flush |=> vic_ptr == (($past(vic_ptr) == PTR_W'(ENTRIES - 1)) ? '0 : $past(vic_ptr) + 1'b1));

  assert_uc_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && (lk_va & UC_WIN) == UC_WIN |=> rsp_uncached);

  assert_hit_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid && $past(lk_valid));

endmodule

bind asid_tlb tlb_chk #(
  .ENTRIES(ENTRIES), .VA_W(VA_W), .PFN_W(PFN_W),
  .PTR_W(PTR_W), .IDX_W(IDX_W), .UC_WIN(UC_WIN)
) u_tlb_chk (.*);

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;

  localparam int N = 6;
  localparam int VA_W = 32, PFN_W = 20, ASID_W = 8;
  localparam int VPN_W = 20, PTR_W = 3, IDX_W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic lk_valid, lk_ifetch;
  logic [VA_W-1:0] lk_va;
  logic [ASID_W-1:0] lk_asid;
  logic rsp_valid, rsp_hit, rsp_uncached, rsp_fault;
  logic [PFN_W-1:0] rsp_pfn;
  logic pr_valid, pr_done;
  logic [VPN_W-1:0] pr_vpn;
  logic [ASID_W-1:0] pr_asid;
  logic [IDX_W-1:0] pr_index;
  logic wr_en, wr_global, wr_v0, wr_v1, wr_err;
  logic [IDX_W-1:0] wr_idx;
  logic [VPN_W-1:0] wr_vpn, wr_mask;
  logic [ASID_W-1:0] wr_asid;
  logic [PFN_W-1:0] wr_pfn;
  logic flush, vic_adv, vic_occ;
  logic [PTR_W-1:0] vic_ptr;
  logic [VPN_W-1:0] vic_vpn;
  logic [PFN_W-1:0] vic_pfn;

  asid_tlb #(.ENTRIES(N), .VA_W(VA_W), .PFN_W(PFN_W), .ASID_W(ASID_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid), .lk_ifetch(lk_ifetch),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn),
    .rsp_uncached(rsp_uncached), .rsp_fault(rsp_fault),
    .pr_valid(pr_valid), .pr_vpn(pr_vpn), .pr_asid(pr_asid),
    .pr_done(pr_done), .pr_index(pr_index),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_v0(wr_v0), .wr_v1(wr_v1),
    .wr_pfn(wr_pfn), .wr_err(wr_err),
    .flush(flush), .vic_adv(vic_adv), .vic_ptr(vic_ptr),
    .vic_vpn(vic_vpn), .vic_pfn(vic_pfn), .vic_occ(vic_occ)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  asid;
    logic        ifetch;
    logic        hit;
    logic [19:0] pfn;
    logic        uc;
    logic        flt;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{32'h0001_0000, 8'd5,  1'b0, 1'b1, 20'hAAAA0, 1'b0, 1'b0}, // R2 tag match
    '{32'h0001_0004, 8'd9,  1'b0, 1'b1, 20'hDDDD3, 1'b0, 1'b0}, // R2 other tag, same page
    '{32'h0001_0000, 8'd6,  1'b0, 1'b0, 20'h00000, 1'b0, 1'b0}, // R2 tag mismatch
    '{32'h0002_F000, 8'd7,  1'b0, 1'b1, 20'hBBBB1, 1'b0, 1'b0}, // R1 masked bits
    '{32'h0002_0000, 8'd7,  1'b0, 1'b1, 20'hBBBB1, 1'b0, 1'b0}, // R3 lowest of two
    '{32'h0003_0000, 8'd99, 1'b0, 1'b1, 20'hCCCC2, 1'b0, 1'b0}, // R2 shared slot
    '{32'h0004_0000, 8'd5,  1'b0, 1'b0, 20'h00000, 1'b0, 1'b0}, // R5 empty slot
    '{32'h0013_0000, 8'd7,  1'b0, 1'b0, 20'h00000, 1'b0, 1'b0}, // R1 unmasked bit differs
    '{32'hA001_0000, 8'd5,  1'b0, 1'b0, 20'h00000, 1'b1, 1'b0}, // R9 window
    '{32'hB003_0000, 8'd0,  1'b0, 1'b0, 20'h00000, 1'b1, 1'b0}, // R9 window plus more
    '{32'h2000_0000, 8'd0,  1'b0, 1'b0, 20'h00000, 1'b0, 1'b0}, // R9 partial
    '{32'h0001_0002, 8'd5,  1'b1, 1'b0, 20'h00000, 1'b0, 1'b1}, // R10 misaligned fetch
    '{32'h0001_0000, 8'd5,  1'b1, 1'b1, 20'hAAAA0, 1'b0, 1'b0}  // R10 aligned fetch
  };

  task automatic idle();
    lk_valid = 0; lk_va = '0; lk_asid = '0; lk_ifetch = 0;
    pr_valid = 0; pr_vpn = '0; pr_asid = '0;
    wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_mask = '0; wr_asid = '0;
    wr_global = 0; wr_v0 = 0; wr_v1 = 0; wr_pfn = '0;
    flush = 0; vic_adv = 0;
  endtask

  task automatic set_wr(input int idx, input logic [19:0] vpn, input logic [19:0] msk,
                        input logic [7:0] asid, input logic g, input logic v0,
                        input logic v1, input logic [19:0] pfn);
    wr_en = 1; wr_idx = IDX_W'(idx); wr_vpn = vpn; wr_mask = msk;
    wr_asid = asid; wr_global = g; wr_v0 = v0; wr_v1 = v1; wr_pfn = pfn;
  endtask

  task automatic do_wr(input int idx, input logic [19:0] vpn, input logic [19:0] msk,
                       input logic [7:0] asid, input logic g, input logic v0,
                       input logic v1, input logic [19:0] pfn);
    @(negedge clk);
    set_wr(idx, vpn, msk, asid, g, v0, v1, pfn);
    @(negedge clk);
    idle();
  endtask

  task automatic do_lk(input logic [31:0] va, input logic [7:0] asid, input logic ifetch);
    @(negedge clk);
    lk_valid = 1; lk_va = va; lk_asid = asid; lk_ifetch = ifetch;
    @(negedge clk);
    idle();
  endtask

  task automatic do_pr(input logic [19:0] vpn, input logic [7:0] asid, input logic [3:0] exp, input string what);
    @(negedge clk);
    pr_valid = 1; pr_vpn = vpn; pr_asid = asid;
    @(negedge clk);
    idle();
    chk("R4", {63'd0, pr_done}, 64'd1, {what, " done"});
    chk("R4", 64'(pr_index), 64'(exp), what);
  endtask

  task automatic do_adv();
    @(negedge clk);
    vic_adv = 1;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R12 reset state
    chk("R12", {63'd0, rsp_valid | rsp_hit | rsp_fault | rsp_uncached}, 64'd0, "rsp flags");
    chk("R12", 64'(vic_ptr), 64'd0, "vic_ptr");
    chk("R12", {63'd0, wr_err}, 64'd0, "wr_err");
    chk("R12", 64'(pr_index), 64'hF, "pr_index");
    chk("R12", {63'd0, vic_occ}, 64'd0, "slot 0 empty");

    // preload
    do_wr(0, 20'h00010, 20'h0, 8'd5, 0, 1, 0, 20'hAAAA0);
    chk("R6", {63'd0, wr_err}, 64'd0, "accepted write");
    do_wr(1, 20'h00020, 20'h0000F, 8'd7, 0, 0, 1, 20'hBBBB1);
    do_wr(2, 20'h00030, 20'h0, 8'd0, 1, 1, 0, 20'hCCCC2);
    do_wr(3, 20'h00010, 20'h0, 8'd9, 0, 1, 0, 20'hDDDD3);
    do_wr(4, 20'h00020, 20'h0, 8'd7, 0, 1, 0, 20'hEEEE4);
    do_wr(5, 20'h00040, 20'h0, 8'd5, 0, 0, 0, 20'hFFFF5);

    // vector table
    for (int i = 0; i < 13; i++) begin
      do_lk(VECS[i].va, VECS[i].asid, VECS[i].ifetch);
      chk("R3", {63'd0, rsp_valid}, 64'd1, $sformatf("vec%0d valid", i));
      chk("R1/R2/R3", {63'd0, rsp_hit}, {63'd0, VECS[i].hit}, $sformatf("vec%0d hit", i));
      chk("R3", 64'(rsp_pfn), 64'(VECS[i].pfn), $sformatf("vec%0d pfn", i));
      chk("R9", {63'd0, rsp_uncached}, {63'd0, VECS[i].uc}, $sformatf("vec%0d uc", i));
      chk("R10", {63'd0, rsp_fault}, {63'd0, VECS[i].flt}, $sformatf("vec%0d fault", i));
    end

    // probes
    do_pr(20'h00020, 8'd7, 4'd1, "R4 dup page lowest");
    do_pr(20'h00010, 8'd9, 4'd3, "R4 tag slot 3");
    do_pr(20'h00010, 8'd1, 4'hF, "R4 not found");
    do_pr(20'h00040, 8'd5, 4'hF, "R5 empty slot probe");

    // out-of-range writes R6
    do_wr(6, 20'h00077, 20'h0, 8'd1, 0, 1, 0, 20'h77777);
    chk("R6", {63'd0, wr_err}, 64'd1, "idx 6 rejected");
    do_wr(15, 20'h00077, 20'h0, 8'd1, 0, 1, 0, 20'h77777);
    chk("R6", {63'd0, wr_err}, 64'd1, "idx 15 rejected");
    do_lk(32'h0007_7000, 8'd1, 0);
    chk("R6", {63'd0, rsp_hit}, 64'd0, "rejected write not stored");
    do_pr(20'h00030, 8'd0, 4'd2, "R6 slot 2 intact");

    // R11 same-cycle write and lookup
    @(negedge clk);
    set_wr(0, 20'h00010, 20'h0, 8'd5, 0, 1, 1, 20'h12345);
    lk_valid = 1; lk_va = 32'h0001_0000; lk_asid = 8'd5;
    @(negedge clk);
    idle();
    chk("R11", 64'(rsp_pfn), 64'hAAAA0, "old contents same cycle");
    do_lk(32'h0001_0000, 8'd5, 0);
    chk("R11", 64'(rsp_pfn), 64'h12345, "new contents next cycle");

    // R8 victim pointer
    chk("R8", 64'(vic_pfn), 64'h12345, "vic slot 0 pfn");
    for (int k = 0; k < 5; k++) do_adv();
    chk("R8", 64'(vic_ptr), 64'd5, "ptr at last");
    chk("R5", {63'd0, vic_occ}, 64'd0, "slot 5 both valid clear");
    chk("R8", 64'(vic_vpn), 64'h00040, "vic slot 5 vpn");
    do_adv();
    chk("R8", 64'(vic_ptr), 64'd0, "ptr wraps");
    do_adv();
    do_adv();
    chk("R8", 64'(vic_ptr), 64'd2, "ptr two");
    chk("R5", {63'd0, vic_occ}, 64'd1, "slot 2 occupied");

    // R7 flush with concurrent write
    @(negedge clk);
    flush = 1;
    set_wr(2, 20'h00055, 20'h0, 8'd3, 1, 1, 0, 20'h55555);
    @(negedge clk);
    idle();
    chk("R7", 64'(vic_ptr), 64'd0, "ptr cleared");
    chk("R7", {63'd0, vic_occ}, 64'd0, "slot 0 cleared");
    do_lk(32'h0003_0000, 8'd0, 0);
    chk("R7", {63'd0, rsp_hit}, 64'd0, "shared slot gone");
    do_lk(32'h0005_5000, 8'd3, 0);
    chk("R7", {63'd0, rsp_hit}, 64'd0, "concurrent write discarded");
    do_pr(20'h00010, 8'd5, 4'hF, "R7 probe after flush");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule